// File: doc/BRIEF.md
# Raster Timing Generator

This block drives the raster timing of a flat panel from a single logic clock. It divides the logic clock into a pixel period and emits a one-cycle pixel clock enable plus a pixel clock waveform. It walks a horizontal counter and a vertical counter through sync, back porch, active and front porch regions, and decodes horizontal sync, vertical sync and data enable from them. For passive panels it also produces an AC-bias toggle counted in lines.

Three 32-bit timing words set the geometry, the divider, the AC-bias period and the output polarities. The block captures them, together with the panel type, while it is disabled. It holds them for as long as it runs, so a host can prepare the next mode without disturbing the current frame. The running pixel and line positions and a frame-end pulse let a pixel fetch engine follow the raster.

Top module: `raster_timing_gen`

## Requirements
- R1: While in reset or disabled, the counters sit at zero, the pixel clock enable and frame-end are low, and hsync, vsync, data enable and the pixel clock sit at their inactive level. The inactive level is 0 before the polarity inversion of R8 is applied. After reset every output is 0.
- R2: The pixel clock enable pulses for one cycle every N logic cycles. N is the divider (timing word 2, bits 7:0) raised to a floor of 2 for an active-matrix panel or 3 for a passive panel. The largest value, 255, is used as is.
- R3: Within each pixel period, before inversion, the pixel clock is low for the first floor(N/2) cycles and high for the remaining N - floor(N/2) cycles, ending on the enable cycle.
- R4: Timing word 0 defines the line, with every field stored minus one: active pixels in bits 9:0, sync width in bits 15:10, front porch in bits 23:16, back porch in bits 31:24. A line runs sync, back porch, active, front porch. hsync is active for positions below the sync width.
- R5: Timing word 1 defines the frame in lines. Active lines in bits 9:0 and vsync width in bits 15:10 are stored minus one. The front porch (bits 23:16) and back porch (bits 31:24) are stored as plain counts and may be zero. vsync is active on lines below the sync width.
- R6: Data enable is active only when both the pixel position and the line are inside their active regions.
- R7: The position outputs give the current pixel within the whole line and the current line within the whole frame, both starting at 0 on enable. Each advances on a pixel clock enable and wraps at its total. The frame-end output pulses together with the enable of the last pixel of the last line.
- R8: Timing word 2 bits 25:20 select inversions: bit 20 inverts vsync, bit 21 inverts hsync, bit 22 inverts the pixel clock, bit 23 inverts data enable. Bits 24 and 25 have no effect.
- R9: For a passive panel the AC-bias output starts at 0 on enable and toggles after every M+1 completed lines, where M is timing word 2 bits 15:8. For an active-matrix panel it stays 0.
- R10: The timing words and the panel type are captured only while the block is disabled. Changes made while it runs do not take effect until it is disabled and enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the raster; low clears counters and reopens configuration capture |
| panel_active_i | input | 1 | 1 = active-matrix panel, 0 = passive panel |
| timing0_i | input | 32 | Horizontal timing word |
| timing1_i | input | 32 | Vertical timing word |
| timing2_i | input | 32 | Divider, AC-bias period and polarity word |
| pix_ce_o | output | 1 | One-cycle pixel clock enable |
| pix_clk_o | output | 1 | Pixel clock waveform |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| acb_o | output | 1 | AC-bias toggle |
| pix_x_o | output | 12 | Pixel position within the line |
| line_y_o | output | 12 | Line position within the frame |
| frame_end_o | output | 1 | Pulse on the last pixel of the frame |

## Verification
A wrong divider state shows as a pixel period or pixel clock duty error within the first pixel after enable. A wrong horizontal or vertical region boundary shows as a misplaced sync or data enable edge within one line or one frame. A slip in the counters also misplaces the frame-end pulse and the reported positions on the very pixel where it occurs. An AC-bias counter error shows as a toggle in the wrong line, within at most M+1 lines. A shadowing error shows as a geometry change in the frame after the timing words are rewritten mid-run.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned CNT_W   = 12;
  localparam int unsigned DIV_W   = 8;
  localparam int unsigned ACB_W   = 8;

  typedef struct packed {
    logic [CNT_W-1:0] sync_len;
    logic [CNT_W-1:0] bp_len;
    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] fp_len;
  } axis_cfg_t;

  typedef struct packed {
    logic inv_vs;
    logic inv_hs;
    logic inv_pclk;
    logic inv_de;
  } pol_cfg_t;

  // porch_m1 set: porches stored minus one (horizontal); clear: plain counts
  function automatic axis_cfg_t decode_axis(input logic [31:0] w, input logic porch_m1);
    axis_cfg_t c;
    c.act_len  = CNT_W'(w[9:0])   + CNT_W'(1);
    c.sync_len = CNT_W'(w[15:10]) + CNT_W'(1);
    c.fp_len   = CNT_W'(w[23:16]) + CNT_W'(porch_m1);
    c.bp_len   = CNT_W'(w[31:24]) + CNT_W'(porch_m1);
    return c;
  endfunction
endpackage

// File: rtl/rtg_clk_div.sv
module rtg_clk_div #(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned MIN_ACTIVE = 2,
  parameter int unsigned MIN_PASSIVE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             panel_act_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             ce_o,
  output logic             pclk_o
);
  logic [DIV_W-1:0] floor_v, eff, half, cnt_q;
  logic             wrap;

  assign floor_v = panel_act_i ? DIV_W'(MIN_ACTIVE) : DIV_W'(MIN_PASSIVE);
  assign eff     = (div_i < floor_v) ? floor_v : div_i;
  assign half    = eff >> 1;
  assign wrap    = (cnt_q == eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i || wrap) cnt_q <= '0;
    else                    cnt_q <= cnt_q + DIV_W'(1);
  end

  assign ce_o   = run_i & wrap;
  assign pclk_o = run_i & (cnt_q >= half);
endmodule

// File: rtl/rtg_axis_cnt.sv
module rtg_axis_cnt
  import rtg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  axis_cfg_t        cfg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             sync_o,
  output logic             act_o
);
  logic [CNT_W-1:0] cnt_q, act_start, act_end, total;

  assign act_start = cfg_i.sync_len + cfg_i.bp_len;
  assign act_end   = act_start + cfg_i.act_len;
  assign total     = act_end + cfg_i.fp_len;
  assign last_o    = (cnt_q == total - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign sync_o = (cnt_q < cfg_i.sync_len);
  assign act_o  = (cnt_q >= act_start) && (cnt_q < act_end);
endmodule

// File: rtl/rtg_acb.sv
module rtg_acb #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             passive_i,
  input  logic             line_end_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             acb_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             acb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acb_q <= 1'b0;
    end else if (!run_i || !passive_i) begin
      cnt_q <= '0;
      acb_q <= 1'b0;
    end else if (line_end_i) begin
      if (cnt_q == len_i) begin
        cnt_q <= '0;
        acb_q <= ~acb_q;
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  assign acb_o = acb_q;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned MIN_DIV_ACTIVE  = 2,
  parameter int unsigned MIN_DIV_PASSIVE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             panel_active_i,
  input  logic [31:0]      timing0_i,
  input  logic [31:0]      timing1_i,
  input  logic [31:0]      timing2_i,
  output logic             pix_ce_o,
  output logic             pix_clk_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             acb_o,
  output logic [CNT_W-1:0] pix_x_o,
  output logic [CNT_W-1:0] line_y_o,
  output logic             frame_end_o
);
  logic             run_q, panel_act_q;
  axis_cfg_t        h_cfg_q, v_cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [ACB_W-1:0] acb_len_q;
  pol_cfg_t         pol_q;

  logic pix_ce, pclk_raw;
  logic h_last, h_sync, h_act, v_last, v_sync, v_act;
  logic line_end;
  logic unused_bits;

  assign unused_bits = ^{timing2_i[31:24], timing2_i[19:16]};

  // configuration shadow: open only while not running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      panel_act_q <= 1'b0;
      h_cfg_q     <= '0;
      v_cfg_q     <= '0;
      div_q       <= '0;
      acb_len_q   <= '0;
      pol_q       <= '0;
    end else begin
      run_q <= enable_i;
      if (!run_q) begin
        panel_act_q     <= panel_active_i;
        h_cfg_q         <= decode_axis(timing0_i, 1'b1);
        v_cfg_q         <= decode_axis(timing1_i, 1'b0);
        div_q           <= timing2_i[7:0];
        acb_len_q       <= timing2_i[15:8];
        pol_q.inv_vs    <= timing2_i[20];
        pol_q.inv_hs    <= timing2_i[21];
        pol_q.inv_pclk  <= timing2_i[22];
        pol_q.inv_de    <= timing2_i[23];
      end
    end
  end

  rtg_clk_div #(
    .DIV_W      (DIV_W),
    .MIN_ACTIVE (MIN_DIV_ACTIVE),
    .MIN_PASSIVE(MIN_DIV_PASSIVE)
  ) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .panel_act_i(panel_act_q),
    .div_i      (div_q),
    .ce_o       (pix_ce),
    .pclk_o     (pclk_raw)
  );

  rtg_axis_cnt u_hcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .step_i(pix_ce),
    .cfg_i (h_cfg_q),
    .cnt_o (pix_x_o),
    .last_o(h_last),
    .sync_o(h_sync),
    .act_o (h_act)
  );

  assign line_end = pix_ce & h_last;

  rtg_axis_cnt u_vcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .step_i(line_end),
    .cfg_i (v_cfg_q),
    .cnt_o (line_y_o),
    .last_o(v_last),
    .sync_o(v_sync),
    .act_o (v_act)
  );

  rtg_acb #(
    .LEN_W(ACB_W)
  ) u_acb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .passive_i (~panel_act_q),
    .line_end_i(line_end),
    .len_i     (acb_len_q),
    .acb_o     (acb_o)
  );

  assign pix_ce_o    = pix_ce;
  assign frame_end_o = line_end & v_last;
  assign pix_clk_o   = pclk_raw ^ pol_q.inv_pclk;
  assign hsync_o     = (run_q & h_sync) ^ pol_q.inv_hs;
  assign vsync_o     = (run_q & v_sync) ^ pol_q.inv_vs;
  assign de_o        = (run_q & h_act & v_act) ^ pol_q.inv_de;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             run_i,
  input logic             panel_act_i,
  input logic             line_end_i,
  input logic             pix_ce_o,
  input logic             frame_end_o,
  input logic             acb_o,
  input logic [CNT_W-1:0] pix_x_o,
  input logic [CNT_W-1:0] line_y_o
);
  assert_idle_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pix_x_o == '0) && (line_y_o == '0));

  assert_ce_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ce_o |=> !pix_ce_o);

  assert_x_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && enable_i && !pix_ce_o) |=> $stable(pix_x_o));

  assert_y_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && enable_i && !line_end_i) |=> $stable(line_y_o));

  assert_frame_end_on_ce_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> pix_ce_o);

  assert_acb_active_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_act_i |=> !acb_o);

  assert_acb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && enable_i && !line_end_i) |=> $stable(acb_o));
endmodule

bind raster_timing_gen rtg_checker u_rtg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .run_i      (run_q),
  .panel_act_i(panel_act_q),
  .line_end_i (line_end),
  .pix_ce_o   (pix_ce_o),
  .frame_end_o(frame_end_o),
  .acb_o      (acb_o),
  .pix_x_o    (pix_x_o),
  .line_y_o   (line_y_o)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
  import rtg_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, enable, panel_act;
  logic [31:0] t0, t1, t2;
  logic pix_ce, pix_clk, hsync, vsync, de, acb, frame_end;
  logic [CNT_W-1:0] pix_x, line_y;

  raster_timing_gen u_raster_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .panel_active_i(panel_act),
    .timing0_i(t0), .timing1_i(t1), .timing2_i(t2),
    .pix_ce_o(pix_ce), .pix_clk_o(pix_clk), .hsync_o(hsync), .vsync_o(vsync),
    .de_o(de), .acb_o(acb), .pix_x_o(pix_x), .line_y_o(line_y), .frame_end_o(frame_end)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int e_hsw, e_hbp, e_hact, e_hfp, e_vsw, e_vbp, e_vact, e_vfp, e_div, e_acb;
  bit e_passive;
  bit [5:0] e_pol;
  int b_per, b_hi, b_x, b_y, b_lc;
  bit b_acb;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void set_expect(input logic [31:0] a, input logic [31:0] b,
                                     input logic [31:0] c, input bit act);
    int mn;
    e_hact = int'(a[9:0]) + 1;   e_hsw = int'(a[15:10]) + 1;
    e_hfp  = int'(a[23:16]) + 1; e_hbp = int'(a[31:24]) + 1;
    e_vact = int'(b[9:0]) + 1;   e_vsw = int'(b[15:10]) + 1;
    e_vfp  = int'(b[23:16]);     e_vbp = int'(b[31:24]);
    mn = act ? 2 : 3;
    e_div = int'(c[7:0]);
    if (e_div < mn) e_div = mn;
    e_acb = int'(c[15:8]);
    e_pol = c[25:20];
    e_passive = !act;
  endfunction

  task automatic start(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input bit act);
    @(negedge clk);
    enable = 1'b0;
    t0 = a; t1 = b; t2 = c; panel_act = act;
    repeat (3) @(negedge clk);
    set_expect(a, b, c, act);
    b_per = 0; b_hi = 0; b_x = 0; b_y = 0; b_lc = 0; b_acb = 1'b0;
    enable = 1'b1;
  endtask

  task automatic measure(input int nfr, input string tag);
    int fr = 0, guard = 0;
    int m_hs = 0, m_vs = 0, m_de = 0, m_pos = 0, m_fe = 0, m_acb = 0, m_per = 0, m_pclk = 0;
    int htot = e_hsw + e_hbp + e_hact + e_hfp;
    int vtot = e_vsw + e_vbp + e_vact + e_vfp;
    bit ehs, evs, ede, last;
    while (fr < nfr && guard < 100000) begin
      @(negedge clk);
      guard++;
      b_per++;
      if ((pix_clk ^ e_pol[2]) == 1'b1) b_hi++;
      if (acb !== (e_passive ? b_acb : 1'b0)) m_acb++;
      if (pix_ce) begin
        if (b_per != e_div) m_per++;
        if (b_hi != e_div - e_div / 2) m_pclk++;
        b_per = 0; b_hi = 0;
        ehs = (b_x < e_hsw);
        evs = (b_y < e_vsw);
        ede = (b_x >= e_hsw + e_hbp) && (b_x < e_hsw + e_hbp + e_hact) &&
              (b_y >= e_vsw + e_vbp) && (b_y < e_vsw + e_vbp + e_vact);
        if (hsync !== (ehs ^ e_pol[1])) m_hs++;
        if (vsync !== (evs ^ e_pol[0])) m_vs++;
        if (de !== (ede ^ e_pol[3])) m_de++;
        if (int'(pix_x) != b_x || int'(line_y) != b_y) m_pos++;
        last = (b_x == htot - 1) && (b_y == vtot - 1);
        if (frame_end !== last) m_fe++;
        if (b_x == htot - 1) begin
          b_x = 0;
          b_lc++;
          if (b_lc == e_acb + 1) begin b_lc = 0; b_acb = ~b_acb; end
          if (b_y == vtot - 1) begin b_y = 0; fr++; end
          else b_y++;
        end else begin
          b_x++;
        end
      end else if (frame_end !== 1'b0) begin
        m_fe++;
      end
    end
    check(fr == nfr, tag, "R7 frames completed", fr, nfr);
    check(m_per == 0, tag, "R2 pixel period mismatches", m_per, 0);
    check(m_pclk == 0, tag, "R3 pixel clock duty mismatches", m_pclk, 0);
    check(m_hs == 0, tag, "R4 R8 hsync mismatches", m_hs, 0);
    check(m_vs == 0, tag, "R5 R8 vsync mismatches", m_vs, 0);
    check(m_de == 0, tag, "R6 R8 data enable mismatches", m_de, 0);
    check(m_pos == 0, tag, "R7 position mismatches", m_pos, 0);
    check(m_fe == 0, tag, "R7 frame end mismatches", m_fe, 0);
    check(m_acb == 0, tag, "R9 ac-bias mismatches", m_acb, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb, rc;
    void'($urandom(32'd4711));
    rst_n = 1'b0; enable = 1'b0; panel_act = 1'b1;
    t0 = '0; t1 = '0; t2 = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({pix_ce, pix_clk, hsync, vsync, de, acb, frame_end} == 7'b0, "reset", "R1 flag outputs",
          {pix_ce, pix_clk, hsync, vsync, de, acb, frame_end}, 0);
    check(pix_x == '0 && line_y == '0, "reset", "R1 positions", pix_x, 0);
    rst_n = 1'b1;

    // R1 R8 idle levels with all inversions, bits 24/25 set too
    t2 = 32'h03F0_0005;
    repeat (4) @(negedge clk);
    check({hsync, vsync, de, pix_clk} == 4'b1111, "idle", "R1 R8 inverted idle levels",
          {hsync, vsync, de, pix_clk}, 15);
    check(!pix_ce && pix_x == '0 && acb == 1'b0, "idle", "R1 no enable pulse", pix_ce, 0);

    // R2 clamp: active panel, divider 1 -> 2
    start(32'h0100_0003, 32'h0001_0002, 32'h0000_0001, 1'b1);
    measure(1, "clamp_active");
    // R2 clamp: passive panel, divider 2 -> 3; R9 acb period 1 line
    start(32'h0001_0402, 32'h0100_0401, 32'h0000_0002, 1'b0);
    measure(1, "clamp_passive");
    // R2 maximum divider
    start(32'h0000_0000, 32'h0000_0000, 32'h0040_01FF, 1'b0);
    measure(1, "div_max");
    // R5 zero vertical porches, R9 active panel keeps acb low
    start(32'h0201_0805, 32'h0000_0803, 32'h00A0_0304, 1'b1);
    measure(2, "zero_vporch");

    // R10 shadowing: rewrite words mid-run, old geometry must persist
    start(32'h0102_0404, 32'h0101_0402, 32'h0020_0103, 1'b0);
    measure(1, "shadow_a");
    t0 = 32'h0000_0001; t1 = 32'h0000_0000; t2 = 32'h0000_0002; panel_act = 1'b1;
    measure(1, "R10 shadow_hold");
    start(32'h0000_0001, 32'h0000_0000, 32'h0000_0002, 1'b1);
    measure(1, "R10 shadow_reload");

    // constrained random configurations
    for (int i = 0; i < 14; i++) begin
      ra = {8'($urandom % 4), 8'($urandom % 4), 6'($urandom % 4), 10'($urandom % 8)};
      rb = {8'($urandom % 4), 8'($urandom % 4), 6'($urandom % 3), 10'($urandom % 5)};
      rc = {6'd0, 6'($urandom % 64), 4'($urandom % 16), 8'($urandom % 4), 8'($urandom % 8)};
      start(ra, rb, rc, 1'($urandom % 2));
      measure(1, $sformatf("rand%0d", i));
    end

    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check(pix_x == '0 && line_y == '0 && !pix_ce, "disable", "R1 counters cleared", pix_x, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule